// File: doc/BRIEF.md
# Timer Interrupt Register Front End

This block is the 32-bit register side of a timekeeping core. The core raises two single-cycle event pulses: one when an alarm matches and one on each seconds tick. The block records them in an interrupt status word and gates them with a mask. It drives one interrupt line per event. Software clears status bits by writing ones to them. Software never writes a mask directly. It uses a pair of registers instead: one that unmasks and one that masks.

The same status, mask and unmask/mask scheme guards a second source, the address trap. Any access whose word index falls past the last defined register is trapped. A trapped read returns zero, a trapped write changes nothing, and either one sets the address-error status bit. That bit drives its own maskable interrupt line.

The register set also has a control word and a free scratch word. Only some control bits are implemented. Its reset value depends on a revision parameter. The bus uses a request/acknowledge handshake with word-sized accesses. Every request cycle is acknowledged in the following cycle.

Top module: `tk_reg_front`

## Requirements
- R1: After reset the interrupt status and error status are 0, the interrupt mask reads 0x3 and the error mask reads 0x1. The control word reads 0x01000000 with REV=1 and 0x02000000 with REV=2. Scratch is 0 and all three interrupt lines are low.
- R2: Interrupt status sits at byte offset 0x00, with bit 0 for alarm and bit 1 for seconds. A pulse on `alarm_evt` or `sec_evt` sets its bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R3: The interrupt mask at 0x04 is read-only, and writes to it have no effect. A write to 0x08 clears every mask bit written as 1. A write to 0x0C sets every mask bit written as 1. Both 0x08 and 0x0C read as zero.
- R4: `irq_alarm` is status bit 0 AND NOT mask bit 0, and `irq_sec` is the same for bit 1. A line shows a status or mask change from the clock edge that makes the change.
- R5: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R6: Any access at byte offset 0x28 or above sets error status bit 0. A trapped read returns 0, and a trapped write changes no other register. Offset 0x24 is the last valid register.
- R7: Error status sits at 0x10 and clears when a 1 is written to it. The error mask at 0x14 is read-only, is cleared through 0x18 and is set through 0x1C. `irq_adderr` is status AND NOT mask.
- R8: The control word is at 0x20. Bits in 0x70FFFFFE are reserved: they read 0 and ignore writes. The other bits read back what was written.
- R9: The scratch word at 0x24 stores and returns all 32 bits.
- R10: `ack` is high in the cycle after each request cycle and low otherwise. `rdata` is valid with `ack` and is 0 for writes. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, one access per cycle held |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access acknowledge |
| rdata | output | 32 | Read data, valid with ack |
| alarm_evt | input | 1 | Alarm event pulse from the timekeeping core |
| sec_evt | input | 1 | Seconds event pulse from the timekeeping core |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_sec | output | 1 | Seconds interrupt |
| irq_adderr | output | 1 | Address-error interrupt |

## Verification
A hardware event and a software clear can hit the same interrupt status bit on one clock edge. The bench provokes this by raising `alarm_evt` in the same cycle as a request that writes ones to both status bits. Reading the status back must show that the alarm bit survived while the seconds bit was cleared, and `irq_alarm` must still be high. The other overlap, a trapped access setting the error bit, cannot collide with a clear, because a clear is always an in-range write.

// File: rtl/tk_reg_pkg.sv
package tk_reg_pkg;
   localparam int DATA_W   = 32;
   localparam int NUM_REGS = 10;
   // word indices of the register map
   localparam int IX_ST    = 0;
   localparam int IX_MSK   = 1;
   localparam int IX_EN    = 2;
   localparam int IX_DIS   = 3;
   localparam int IX_EST   = 4;
   localparam int IX_EMSK  = 5;
   localparam int IX_EEN   = 6;
   localparam int IX_EDIS  = 7;
   localparam int IX_CTRL  = 8;
   localparam int IX_SCR   = 9;
   localparam logic [DATA_W-1:0] CTRL_RSVD  = 32'h70FF_FFFE;
   localparam logic [DATA_W-1:0] CTRL_RST_1 = 32'h0100_0000;
   localparam logic [DATA_W-1:0] CTRL_RST_2 = 32'h0200_0000;
endpackage

// File: rtl/tk_addr_decode.sv
module tk_addr_decode
   import tk_reg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic                req,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel,
   output logic                oob
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic [1:0]       unused_lo;

   assign idx       = addr[ADDR_W-1:2];
   assign unused_lo = addr[1:0];
   assign oob       = req && (idx >= IDX_W'(NUM_REGS));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign sel[i] = req && (idx == IDX_W'(i));
   end

   // R6: a trapped access selects no register
   always_comb begin
      if (oob) p_oob_nosel_r6: assert (sel == '0);
      p_sel_onehot_r6: assert ($onehot0(sel));
   end
endmodule

// File: rtl/tk_irq_group.sv
module tk_irq_group #(
   parameter int           W        = 2,
   parameter logic [W-1:0] MASK_RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr_we,
   input  logic         en_we,
   input  logic         dis_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] status,
   output logic [W-1:0] mask,
   output logic [W-1:0] irq
);
   if (W < 1 || W > 32) begin : g_chk_w
      $error("tk_irq_group: W must be 1..32");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                     status[i] <= 1'b0;
         else if (evt[i])                status[i] <= 1'b1;   // event wins
         else if (clr_we && wdata[i])    status[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                     mask[i] <= MASK_RST[i];
         else if (en_we && wdata[i])     mask[i] <= 1'b0;
         else if (dis_we && wdata[i])    mask[i] <= 1'b1;
      end

      assign irq[i] = status[i] & ~mask[i];

      p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> status[i]);
      p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wdata[i] && !evt[i]) |=> !status[i]);
      p_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (en_we && wdata[i]) |=> !mask[i]);
      p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (dis_we && wdata[i] && !en_we) |=> mask[i]);
      p_hold_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_we && !dis_we) |=> $stable(mask[i]));
   end
endmodule

// File: rtl/tk_reg_front.sv
module tk_reg_front
   import tk_reg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int REV    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic              ack,
   output logic [31:0]       rdata,
   input  logic              alarm_evt,
   input  logic              sec_evt,
   output logic              irq_alarm,
   output logic              irq_sec,
   output logic              irq_adderr
);
   localparam int IRQ_N = 2;

   if (ADDR_W < 6 || ADDR_W > 32) begin : g_chk_addr
      $error("tk_reg_front: ADDR_W must be 6..32");
   end
   if (REV != 1 && REV != 2) begin : g_chk_rev
      $error("tk_reg_front: REV must be 1 or 2");
   end

   logic [NUM_REGS-1:0] sel;
   logic                oob;
   logic                wr;
   logic [IRQ_N-1:0]    int_st, int_msk, int_irq;
   logic [0:0]          err_st, err_msk, err_irq;
   logic [31:0]         ctrl_q, scr_q, ctrl_rst, rd_mux;

   assign wr = req && we;

   tk_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req  (req),
      .addr (addr),
      .sel  (sel),
      .oob  (oob)
   );

   tk_irq_group #(.W(IRQ_N), .MASK_RST(2'b11)) u_int (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    ({sec_evt, alarm_evt}),
      .clr_we (wr && sel[IX_ST]),
      .en_we  (wr && sel[IX_EN]),
      .dis_we (wr && sel[IX_DIS]),
      .wdata  (wdata[IRQ_N-1:0]),
      .status (int_st),
      .mask   (int_msk),
      .irq    (int_irq)
   );

   tk_irq_group #(.W(1), .MASK_RST(1'b1)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (oob),
      .clr_we (wr && sel[IX_EST]),
      .en_we  (wr && sel[IX_EEN]),
      .dis_we (wr && sel[IX_EDIS]),
      .wdata  (wdata[0:0]),
      .status (err_st),
      .mask   (err_msk),
      .irq    (err_irq)
   );

   assign irq_alarm  = int_irq[0];
   assign irq_sec    = int_irq[1];
   assign irq_adderr = err_irq[0];

   if (REV == 2) begin : g_rev2
      assign ctrl_rst = CTRL_RST_2;
   end else begin : g_rev1
      assign ctrl_rst = CTRL_RST_1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    ctrl_q <= ctrl_rst & ~CTRL_RSVD;
      else if (wr && sel[IX_CTRL])   ctrl_q <= wdata & ~CTRL_RSVD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    scr_q <= '0;
      else if (wr && sel[IX_SCR])    scr_q <= wdata;
   end

   always_comb begin
      rd_mux = '0;
      if (sel[IX_ST])   rd_mux = 32'(int_st);
      if (sel[IX_MSK])  rd_mux = 32'(int_msk);
      if (sel[IX_EST])  rd_mux = 32'(err_st);
      if (sel[IX_EMSK]) rd_mux = 32'(err_msk);
      if (sel[IX_CTRL]) rd_mux = ctrl_q;
      if (sel[IX_SCR])  rd_mux = scr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack   <= 1'b0;
         rdata <= '0;
      end else begin
         ack   <= req;
         rdata <= (req && !we) ? rd_mux : '0;
      end
   end

   p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ack);
   p_noack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ack);
   p_wr_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we) |=> (rdata == '0));
   p_oob_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      oob |=> err_st[0]);
   p_oob_rdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (oob && !we) |=> (rdata == '0));
   p_scr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel[IX_SCR]) |=> $stable(scr_q));
   p_ctrl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel[IX_CTRL]) |=> $stable(ctrl_q));
   p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_alarm |-> int_st[0]);
endmodule

// File: tb/tb_tk_reg_front.sv
`timescale 1ns/1ps
module tb_tk_reg_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, req2 = 1'b0, we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        alarm_evt = 1'b0, sec_evt = 1'b0;
   logic        ack, ack2, irq_alarm, irq_sec, irq_adderr;
   logic        ia2, is2, ie2;
   logic [31:0] rdata, rdata2;
   int          total = 0, bad = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   tk_reg_front #(.ADDR_W(8), .REV(1)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .ack(ack), .rdata(rdata), .alarm_evt(alarm_evt), .sec_evt(sec_evt),
      .irq_alarm(irq_alarm), .irq_sec(irq_sec), .irq_adderr(irq_adderr));

   tk_reg_front #(.ADDR_W(8), .REV(2)) dut2 (
      .clk(clk), .rst_n(rst_n), .req(req2), .we(we), .addr(addr), .wdata(wdata),
      .ack(ack2), .rdata(rdata2), .alarm_evt(1'b0), .sec_evt(1'b0),
      .irq_alarm(ia2), .irq_sec(is2), .irq_adderr(ie2));

   // {we, addr, wdata, expected rdata}
   localparam int NV = 23;
   localparam logic [72:0] TAB [0:NV-1] = '{
      {1'b0, 8'h00, 32'h0, 32'h0000_0000},   // R1 status
      {1'b0, 8'h04, 32'h0, 32'h0000_0003},   // R1 mask
      {1'b0, 8'h14, 32'h0, 32'h0000_0001},   // R1 err mask
      {1'b0, 8'h20, 32'h0, 32'h0100_0000},   // R1 ctrl REV=1
      {1'b0, 8'h24, 32'h0, 32'h0000_0000},   // R1 scratch
      {1'b1, 8'h24, 32'hA5A5_5A5A, 32'h0},   // R9
      {1'b0, 8'h24, 32'h0, 32'hA5A5_5A5A},   // R9
      {1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},   // R8
      {1'b0, 8'h20, 32'h0, 32'h8F00_0001},   // R8 reserved read 0
      {1'b1, 8'h20, 32'h0, 32'h0},           // R8
      {1'b0, 8'h20, 32'h0, 32'h0},           // R8
      {1'b1, 8'h04, 32'h0, 32'h0},           // R3 mask read-only
      {1'b0, 8'h04, 32'h0, 32'h3},           // R3
      {1'b1, 8'h08, 32'h1, 32'h0},           // R3 unmask alarm
      {1'b0, 8'h04, 32'h0, 32'h2},           // R3
      {1'b0, 8'h08, 32'h0, 32'h0},           // R3 reads zero
      {1'b1, 8'h0C, 32'h1, 32'h0},           // R3 mask alarm
      {1'b0, 8'h04, 32'h0, 32'h3},           // R3
      {1'b1, 8'h18, 32'h1, 32'h0},           // R7 unmask err
      {1'b0, 8'h14, 32'h0, 32'h0},           // R7
      {1'b1, 8'h1C, 32'h1, 32'h0},           // R7 mask err
      {1'b0, 8'h14, 32'h0, 32'h1},           // R7
      {1'b0, 8'h26, 32'h0, 32'hA5A5_5A5A}    // R10 low bits ignored
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input bit two, input logic w, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] r, output logic k);
      we = w; addr = a; wdata = d;
      if (two) req2 = 1'b1; else req = 1'b1;
      @(negedge clk);
      r = two ? rdata2 : rdata;
      k = two ? ack2 : ack;
      req = 1'b0; req2 = 1'b0;
   endtask

   task automatic pulse(input logic [1:0] e);
      {sec_evt, alarm_evt} = e;
      @(negedge clk);
      {sec_evt, alarm_evt} = 2'b00;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic        k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 irq lines", {29'b0, irq_alarm, irq_sec, irq_adderr}, 32'h0);
      chk("R10 ack idle", {31'b0, ack}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         bus(1'b0, TAB[i][72], TAB[i][71:64], TAB[i][63:32], r, k);
         chk($sformatf("R10 ack vec%0d", i), {31'b0, k}, 32'h1);
         chk($sformatf("table vec%0d", i), r, TAB[i][31:0]);
      end

      // R4 / R2: events and lines
      bus(1'b0, 1'b1, 8'h08, 32'h3, r, k);
      chk("R4 alarm low before event", {31'b0, irq_alarm}, 32'h0);
      pulse(2'b01);
      chk("R4 alarm line", {31'b0, irq_alarm}, 32'h1);
      chk("R4 sec line idle", {31'b0, irq_sec}, 32'h0);
      bus(1'b0, 1'b0, 8'h00, 32'h0, r, k);
      chk("R2 alarm status", r, 32'h1);
      pulse(2'b10);
      chk("R4 sec line", {31'b0, irq_sec}, 32'h1);
      bus(1'b0, 1'b1, 8'h0C, 32'h2, r, k);
      chk("R3 mask drops sec line", {31'b0, irq_sec}, 32'h0);
      bus(1'b0, 1'b0, 8'h00, 32'h0, r, k);
      chk("R2 status kept under mask", r, 32'h3);
      bus(1'b0, 1'b1, 8'h00, 32'h0, r, k);
      bus(1'b0, 1'b0, 8'h00, 32'h0, r, k);
      chk("R2 zero write ignored", r, 32'h3);
      bus(1'b0, 1'b1, 8'h00, 32'h1, r, k);
      chk("R2 clear drops alarm line", {31'b0, irq_alarm}, 32'h0);
      bus(1'b0, 1'b0, 8'h00, 32'h0, r, k);
      chk("R2 alarm cleared", r, 32'h2);

      // R5: event and clear collide
      alarm_evt = 1'b1;
      bus(1'b0, 1'b1, 8'h00, 32'h3, r, k);
      alarm_evt = 1'b0;
      bus(1'b0, 1'b0, 8'h00, 32'h0, r, k);
      chk("R5 event beats clear", r, 32'h1);
      chk("R5 alarm line held", {31'b0, irq_alarm}, 32'h1);
      bus(1'b0, 1'b1, 8'h00, 32'h1, r, k);

      // R6 / R7: address trap
      bus(1'b0, 1'b0, 8'h10, 32'h0, r, k);
      chk("R6 valid offsets do not trap", r, 32'h0);
      bus(1'b0, 1'b0, 8'h28, 32'h0, r, k);
      chk("R6 trapped read zero", r, 32'h0);
      chk("R6 trapped read ack", {31'b0, k}, 32'h1);
      chk("R7 masked err line", {31'b0, irq_adderr}, 32'h0);
      bus(1'b0, 1'b0, 8'h10, 32'h0, r, k);
      chk("R7 err status set", r, 32'h1);
      bus(1'b0, 1'b1, 8'h18, 32'h1, r, k);
      chk("R7 err line", {31'b0, irq_adderr}, 32'h1);
      bus(1'b0, 1'b1, 8'h10, 32'h1, r, k);
      chk("R7 err clear line", {31'b0, irq_adderr}, 32'h0);
      bus(1'b0, 1'b0, 8'h10, 32'h0, r, k);
      chk("R7 err cleared", r, 32'h0);
      bus(1'b0, 1'b1, 8'hFC, 32'hFFFF_FFFF, r, k);
      chk("R6 trapped write raises err", {31'b0, irq_adderr}, 32'h1);
      bus(1'b0, 1'b0, 8'h24, 32'h0, r, k);
      chk("R6 scratch untouched", r, 32'hA5A5_5A5A);
      bus(1'b0, 1'b0, 8'h20, 32'h0, r, k);
      chk("R6 ctrl untouched", r, 32'h0);
      bus(1'b0, 1'b0, 8'h04, 32'h0, r, k);
      chk("R6 mask untouched", r, 32'h2);
      bus(1'b0, 1'b0, 8'h14, 32'h0, r, k);
      chk("R6 err mask untouched", r, 32'h0);
      bus(1'b0, 1'b1, 8'h10, 32'h1, r, k);

      // R10: ack drops without request
      @(negedge clk);
      chk("R10 no ack without req", {31'b0, ack}, 32'h0);

      // R1: second revision reset value
      bus(1'b1, 1'b0, 8'h20, 32'h0, r, k);
      chk("R1 ctrl REV=2", r, 32'h0200_0000);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule